// File: doc/BRIEF.md
# Two-Level Interrupt Event Aggregator

This block collects hardware events from a group of peripherals and turns them into one level-sensitive interrupt request per peripheral toward the CPU. Each peripheral owns an event flag register and a mask register of equal width. A flag bit records an event and stays set until software acknowledges it. The enabled flags of a peripheral are ORed into that peripheral's request level.

A second stage holds a pend latch and an enable mask for each peripheral. Software changes both through write-1 set and clear registers. The same stage keeps a sticky missed-event bit for each peripheral. A peripheral's interrupt output is asserted when its pend latch and its enable bit are both set. A small picker reports the lowest-numbered asserted output as the winning request.

Software reaches every register through a single-cycle write port and a combinational read port. Peripheral `p` has its flag register at address `2p` and its mask register at address `2p+1`. The top-stage registers sit at `TOP = 2^(ADDR_W-1)` and upward.

Top module: `irq_event_aggregator`

## Requirements
- R1: An event bit high at a rising edge sets the matching bit of that peripheral's flag register (address 2p, bit b for event bit b), whatever the value of the mask register. The new value can be read after that edge.
- R2: Writing the flag register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R3: When an event and a clear write hit the same flag bit in the same cycle, the flag bit stays set.
- R4: A write to the mask register (address 2p+1) replaces it with the written value. Setting a mask bit whose flag is already set raises the peripheral's level at once, and the pend latch sets at the next edge.
- R5: A peripheral's level is the OR of (flag AND mask) over its bits. Its output stays asserted while any enabled flag remains set.
- R6: If an event arrives on a bit that is enabled, already set and not being cleared in that cycle, the peripheral's bit in the missed register (TOP+5) sets. It stays set until software writes 1 to it, and an event in the same cycle as that clear wins.
- R7: Writing 1s to TOP+0 sets enable bits, and writing 1s to TOP+1 clears them. Written 0s change nothing. Both addresses read back the enable mask.
- R8: Writing 1s to TOP+2 sets pend latches, and writing 1s to TOP+3 clears them. Both addresses read back the pend bits. TOP+4 reads pend AND enable, which equals irq_o, and ignores writes. An output asserts whether the pend bit or the enable bit was set first.
- R9: irq_valid_o is high when any irq_o bit is high, and irq_sel_o then gives the lowest asserted index.
- R10: A pend latch sets at every edge where its peripheral's level is high, so a clear write has no effect while the level persists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | EVT_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | EVT_W | Read data (combinational, 0 for unmapped addresses) |
| evt_i | input | NUM_PERIPH*EVT_W | Event pulses, peripheral p in bits [p*EVT_W +: EVT_W] |
| irq_o | output | NUM_PERIPH | Per-peripheral interrupt (pend AND enable) |
| irq_valid_o | output | 1 | Any interrupt asserted |
| irq_sel_o | output | SEL_W | Lowest-numbered asserted interrupt |

## Verification
The missed-event path is the hardest case to reach. It needs a flag that is already set, a mask bit that is enabled, a repeat event on that same bit, and no clear in the same cycle. The directed part builds this up step by step before the collision. The random part keeps events sparse and mask writes frequent, so that set and enabled flags often meet a second event. The pend-versus-level interplay is hardest to reach next: pend clears are issued on purpose while a level is still held high.

// File: rtl/evagg_pkg.sv
package evagg_pkg;
  // offsets of the top-stage registers above the top base address
  typedef enum logic [2:0] {
    TOP_ENA_SET  = 3'd0,
    TOP_ENA_CLR  = 3'd1,
    TOP_PEND_SET = 3'd2,
    TOP_PEND_CLR = 3'd3,
    TOP_ACTIVE   = 3'd4,
    TOP_MISS     = 3'd5
  } top_reg_e;
endpackage

// File: rtl/evagg_bank.sv
module evagg_bank #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt_i,
  input  logic [DW-1:0] clr_i,
  input  logic          cfg_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] flag_q,
  output logic [DW-1:0] cfg_q,
  output logic          level_o,
  output logic          miss_o
);
  logic [DW-1:0] flag_d;
  logic [DW-1:0] cfg_d;

  always_comb begin
    flag_d  = (flag_q & ~clr_i) | evt_i;
    cfg_d   = cfg_we ? wdata : cfg_q;
    level_o = |(flag_q & cfg_q);
    miss_o  = |(evt_i & cfg_q & flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      cfg_q  <= '0;
    end else begin
      flag_q <= flag_d;
      if (cfg_we) cfg_q <= cfg_d;
    end
  end
endmodule

// File: rtl/evagg_top_stage.sv
module evagg_top_stage #(
  parameter int unsigned NP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] level_i,
  input  logic [NP-1:0] miss_i,
  input  logic [NP-1:0] en_set,
  input  logic [NP-1:0] en_clr,
  input  logic [NP-1:0] pd_set,
  input  logic [NP-1:0] pd_clr,
  input  logic [NP-1:0] ms_clr,
  output logic [NP-1:0] en_q,
  output logic [NP-1:0] pend_q,
  output logic [NP-1:0] miss_q,
  output logic [NP-1:0] req_o
);
  logic [NP-1:0] en_d, pend_d, miss_d;

  always_comb begin
    en_d   = (en_q | en_set) & ~en_clr;
    pend_d = (pend_q & ~pd_clr) | pd_set | level_i;
    miss_d = (miss_q & ~ms_clr) | miss_i;
    req_o  = pend_q & en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      miss_q <= '0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
      miss_q <= miss_d;
    end
  end
endmodule

// File: rtl/evagg_pick.sv
module evagg_pick #(
  parameter int unsigned NP    = 4,
  parameter int unsigned SEL_W = 2
) (
  input  logic [NP-1:0]    req_i,
  output logic             valid_o,
  output logic [SEL_W-1:0] sel_o
);
  always_comb begin
    valid_o = |req_i;
    sel_o   = '0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (req_i[i]) sel_o = SEL_W'(i);
    end
  end
endmodule

// File: rtl/irq_event_aggregator.sv
module irq_event_aggregator #(
  parameter int unsigned NUM_PERIPH = 4,
  parameter int unsigned EVT_W      = 8,
  parameter int unsigned ADDR_W     = 5,
  localparam int unsigned SEL_W     = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [EVT_W-1:0]            wr_data,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [EVT_W-1:0]            rd_data,
  input  logic [NUM_PERIPH*EVT_W-1:0] evt_i,
  output logic [NUM_PERIPH-1:0]       irq_o,
  output logic                        irq_valid_o,
  output logic [SEL_W-1:0]            irq_sel_o
);
  import evagg_pkg::*;

  localparam int unsigned NP = NUM_PERIPH;
  localparam logic [ADDR_W-1:0] TOP_BASE = ADDR_W'(1) << (ADDR_W - 1);

  // reset: asynchronous assertion, synchronous release
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  function automatic logic [ADDR_W-1:0] top_addr(input top_reg_e r);
    return TOP_BASE + ADDR_W'(r);
  endfunction

  logic [NP*EVT_W-1:0] flag_all, cfg_all, clr_all;
  logic [NP-1:0]       level, miss_evt, cfg_we;
  logic [NP-1:0]       en_set, en_clr, pd_set, pd_clr, ms_clr;
  logic [NP-1:0]       en_q, pend_q, miss_q, req;

  genvar gp;
  generate
    for (gp = 0; gp < NP; gp++) begin : g_bank
      assign clr_all[gp*EVT_W +: EVT_W] =
        (wr_en && wr_addr == ADDR_W'(2*gp)) ? wr_data : '0;
      assign cfg_we[gp] = wr_en && wr_addr == ADDR_W'(2*gp+1);

      evagg_bank #(.DW(EVT_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_sync),
        .evt_i   (evt_i[gp*EVT_W +: EVT_W]),
        .clr_i   (clr_all[gp*EVT_W +: EVT_W]),
        .cfg_we  (cfg_we[gp]),
        .wdata   (wr_data),
        .flag_q  (flag_all[gp*EVT_W +: EVT_W]),
        .cfg_q   (cfg_all[gp*EVT_W +: EVT_W]),
        .level_o (level[gp]),
        .miss_o  (miss_evt[gp])
      );
    end
  endgenerate

  always_comb begin
    en_set = (wr_en && wr_addr == top_addr(TOP_ENA_SET))  ? wr_data[NP-1:0] : '0;
    en_clr = (wr_en && wr_addr == top_addr(TOP_ENA_CLR))  ? wr_data[NP-1:0] : '0;
    pd_set = (wr_en && wr_addr == top_addr(TOP_PEND_SET)) ? wr_data[NP-1:0] : '0;
    pd_clr = (wr_en && wr_addr == top_addr(TOP_PEND_CLR)) ? wr_data[NP-1:0] : '0;
    ms_clr = (wr_en && wr_addr == top_addr(TOP_MISS))     ? wr_data[NP-1:0] : '0;
  end

  evagg_top_stage #(.NP(NP)) u_top (
    .clk     (clk),
    .rst_n   (rst_sync),
    .level_i (level),
    .miss_i  (miss_evt),
    .en_set  (en_set),
    .en_clr  (en_clr),
    .pd_set  (pd_set),
    .pd_clr  (pd_clr),
    .ms_clr  (ms_clr),
    .en_q    (en_q),
    .pend_q  (pend_q),
    .miss_q  (miss_q),
    .req_o   (req)
  );

  evagg_pick #(.NP(NP), .SEL_W(SEL_W)) u_pick (
    .req_i   (req),
    .valid_o (irq_valid_o),
    .sel_o   (irq_sel_o)
  );

  assign irq_o = req;

  always_comb begin
    rd_data = '0;
    for (int p = 0; p < NP; p++) begin
      if (rd_addr == ADDR_W'(2*p))   rd_data = flag_all[p*EVT_W +: EVT_W];
      if (rd_addr == ADDR_W'(2*p+1)) rd_data = cfg_all[p*EVT_W +: EVT_W];
    end
    if (rd_addr == top_addr(TOP_ENA_SET) || rd_addr == top_addr(TOP_ENA_CLR))
      rd_data = EVT_W'(en_q);
    if (rd_addr == top_addr(TOP_PEND_SET) || rd_addr == top_addr(TOP_PEND_CLR))
      rd_data = EVT_W'(pend_q);
    if (rd_addr == top_addr(TOP_ACTIVE)) rd_data = EVT_W'(req);
    if (rd_addr == top_addr(TOP_MISS))   rd_data = EVT_W'(miss_q);
  end
endmodule

// File: rtl/irq_event_aggregator_chk.sv
module irq_event_aggregator_chk #(
  parameter int unsigned NP    = 4,
  parameter int unsigned DW    = 8,
  parameter int unsigned SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NP*DW-1:0] evt_i,
  input logic [NP*DW-1:0] flag_all,
  input logic [NP*DW-1:0] clr_all,
  input logic [NP-1:0]    level,
  input logic [NP-1:0]    miss_evt,
  input logic [NP-1:0]    miss_q,
  input logic [NP-1:0]    pend_q,
  input logic [NP-1:0]    en_q,
  input logic [NP-1:0]    en_clr,
  input logic [NP-1:0]    irq_o,
  input logic             irq_valid_o,
  input logic [SEL_W-1:0] irq_sel_o
);
  logic [NP-1:0] lo_mask;
  always_comb lo_mask = (NP'(1) << irq_sel_o) - NP'(1);

  // R1
  evt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((flag_all & $past(evt_i)) == $past(evt_i)));

  // R2
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flag_all) & ~flag_all) & ~$past(clr_all)) == '0));

  // R3
  clear_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i & clr_all) != '0) |=>
      ((flag_all & $past(evt_i & clr_all)) == $past(evt_i & clr_all)));

  // R6
  miss_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_evt != '0) |=> ((miss_q & $past(miss_evt)) == $past(miss_evt)));

  // R7
  en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(en_q) & ~en_q & ~$past(en_clr)) == '0));

  // R10
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level != '0) |=> ((pend_q & $past(level)) == $past(level)));

  // R9
  pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> (irq_o[irq_sel_o] && ((irq_o & lo_mask) == '0)));

  // R9
  pick_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o == (irq_o != '0));
endmodule

bind irq_event_aggregator irq_event_aggregator_chk #(
  .NP(NUM_PERIPH), .DW(EVT_W), .SEL_W(SEL_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_i       (evt_i),
  .flag_all    (flag_all),
  .clr_all     (clr_all),
  .level       (level),
  .miss_evt    (miss_evt),
  .miss_q      (miss_q),
  .pend_q      (pend_q),
  .en_q        (en_q),
  .en_clr      (en_clr),
  .irq_o       (irq_o),
  .irq_valid_o (irq_valid_o),
  .irq_sel_o   (irq_sel_o)
);

// File: tb/irq_event_aggregator_tb.sv
module irq_event_aggregator_tb;
  localparam int NP = 4;
  localparam int DW = 8;
  localparam int AW = 5;
  localparam int TOP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NP*DW-1:0] evt = '0;
  logic [DW-1:0] rd_data;
  logic [NP-1:0] irq;
  logic irq_valid;
  logic [1:0] irq_sel;

  always #10 clk = ~clk;

  irq_event_aggregator #(.NUM_PERIPH(NP), .EVT_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .evt_i(evt),
    .irq_o(irq), .irq_valid_o(irq_valid), .irq_sel_o(irq_sel));

  // reference state computed from the requirements
  logic [DW-1:0] m_flag [NP];
  logic [DW-1:0] m_cfg  [NP];
  logic [NP-1:0] m_en, m_pend, m_miss;

  int checks = 0, errors = 0;
  string cur = "reset";
  bit done = 1'b0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin m_flag[p] = '0; m_cfg[p] = '0; end
      m_en = '0; m_pend = '0; m_miss = '0;
    end else begin
      logic [NP-1:0] lvl, mis, es, ec, ps, pc, mc;
      for (int p = 0; p < NP; p++) begin
        logic [DW-1:0] c, e;
        c = (wr_en && wr_addr == AW'(2*p)) ? wr_data : '0;
        e = evt[p*DW +: DW];
        lvl[p] = |(m_flag[p] & m_cfg[p]);
        mis[p] = |(e & m_cfg[p] & m_flag[p] & ~c);
        m_flag[p] = (m_flag[p] & ~c) | e;
        if (wr_en && wr_addr == AW'(2*p+1)) m_cfg[p] = wr_data;
      end
      es = (wr_en && wr_addr == AW'(TOP+0)) ? wr_data[NP-1:0] : '0;
      ec = (wr_en && wr_addr == AW'(TOP+1)) ? wr_data[NP-1:0] : '0;
      ps = (wr_en && wr_addr == AW'(TOP+2)) ? wr_data[NP-1:0] : '0;
      pc = (wr_en && wr_addr == AW'(TOP+3)) ? wr_data[NP-1:0] : '0;
      mc = (wr_en && wr_addr == AW'(TOP+5)) ? wr_data[NP-1:0] : '0;
      m_en   = (m_en | es) & ~ec;
      m_pend = (m_pend & ~pc) | ps | lvl;
      m_miss = (m_miss & ~mc) | mis;
    end
  end

  function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
    logic [DW-1:0] v = '0;
    for (int p = 0; p < NP; p++) begin
      if (a == AW'(2*p))   v = m_flag[p];
      if (a == AW'(2*p+1)) v = m_cfg[p];
    end
    if (a == AW'(TOP+0) || a == AW'(TOP+1)) v = DW'(m_en);
    if (a == AW'(TOP+2) || a == AW'(TOP+3)) v = DW'(m_pend);
    if (a == AW'(TOP+4)) v = DW'(m_pend & m_en);
    if (a == AW'(TOP+5)) v = DW'(m_miss);
    return v;
  endfunction

  function automatic logic [1:0] model_sel(input logic [NP-1:0] r);
    logic [1:0] s = '0;
    for (int i = NP - 1; i >= 0; i--) if (r[i]) s = 2'(i);
    return s;
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur, what, act, exp);
    end
  endtask

  task automatic check_all();
    logic [NP-1:0] r;
    r = m_pend & m_en;
    chk("rd_data", 32'(rd_data), 32'(model_read(rd_addr)));
    chk("irq", 32'(irq), 32'(r));
    chk("irq_valid", 32'(irq_valid), 32'(|r));
    if (|r) chk("irq_sel", 32'(irq_sel), 32'(model_sel(r)));
  endtask

  task automatic step(input bit we, input int a, input int d, input logic [NP*DW-1:0] e, input int ra);
    wr_en = we; wr_addr = AW'(a); wr_data = DW'(d); evt = e; rd_addr = AW'(ra);
    @(negedge clk);
    check_all();
  endtask

  function automatic logic [NP*DW-1:0] ev(input int p, input int bits);
    return (NP*DW)'(bits) << (p*DW);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cur = "reset";
    for (int a = 0; a < 24; a++) step(0, 0, 0, '0, a);

    cur = "R1 masked event";  step(0, 0, 0, ev(0, 8'h04), 0);
    step(0, 0, 0, '0, TOP+4);
    cur = "R2 write0";        step(1, 0, 8'h00, '0, 0);
    cur = "R2 write1";        step(1, 0, 8'h04, '0, 0);
    cur = "R3 collide";       step(0, 0, 0, ev(0, 8'h01), 0);
    step(1, 0, 8'h01, ev(0, 8'h01), 0);
    cur = "R7 enable set";    step(1, TOP+0, 4'b0001, '0, TOP+0);
    cur = "R7 clear zero";    step(1, TOP+1, 4'b0000, '0, TOP+1);
    cur = "R4 late mask";     step(1, 1, 8'h01, '0, TOP+2);
    step(0, 0, 0, '0, TOP+4);
    step(0, 0, 0, '0, TOP+4);
    cur = "R10 clear vs level"; step(1, TOP+3, 4'b0001, '0, TOP+2);
    step(0, 0, 0, '0, TOP+2);
    cur = "R6 repeat event";  step(0, 0, 0, ev(0, 8'h01), TOP+5);
    cur = "R6 no miss on clear"; step(1, 0, 8'h01, ev(0, 8'h01), TOP+5);
    cur = "R6 miss clear";    step(1, TOP+5, 4'b0001, '0, TOP+5);
    cur = "R2 release";       step(1, 0, 8'h01, '0, TOP+2);
    cur = "R10 pend clear";   step(1, TOP+3, 4'b0001, '0, TOP+2);
    step(0, 0, 0, '0, TOP+4);
    cur = "R8 pend first";    step(1, TOP+2, 4'b0100, '0, TOP+4);
    step(1, TOP+0, 4'b0100, '0, TOP+4);
    cur = "R8 active ro";     step(1, TOP+4, 8'hFF, '0, TOP+4);
    step(0, 0, 0, '0, TOP+4);
    cur = "R9 priority";      step(1, TOP+0, 4'b1010, '0, TOP+4);
    step(1, TOP+2, 4'b1010, '0, TOP+4);
    step(1, TOP+3, 4'b0010, '0, TOP+4);
    cur = "R5 two flags";     step(1, 7, 8'h11, '0, 6);
    step(0, 0, 0, ev(3, 8'h11), 6);
    step(1, 6, 8'h01, '0, TOP+2);
    step(1, TOP+3, 4'b1000, '0, TOP+2);
    step(1, 6, 8'h10, '0, TOP+2);
    step(1, TOP+3, 4'b1000, '0, TOP+2);
    step(0, 0, 0, '0, TOP+4);

    cur = "R5 R6 R9 random";
    void'($urandom(32'h5eed_0017));
    for (int n = 0; n < 4000; n++) begin
      logic [NP*DW-1:0] e;
      int a;
      e = '0;
      for (int b = 0; b < NP*DW; b++) e[b] = ($urandom_range(0, 11) == 0);
      a = ($urandom_range(0, 2) == 0) ? TOP + $urandom_range(0, 7) : $urandom_range(0, 2*NP-1);
      step($urandom_range(0, 1) == 1, a, $urandom_range(0, 255), e,
           ($urandom_range(0, 1) == 1) ? TOP + $urandom_range(0, 5) : $urandom_range(0, 31));
    end
    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 150000 && !done; t++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule